// File: doc/BRIEF.md
# Two-Wire Conversion-Result Slave Interface

This block is the serial front end of a 16-bit conversion device on a two-wire (I2C-style) bus. It samples the bus clock and data lines with the system clock and detects START, repeated START and STOP conditions. It then receives one address byte. The upper three address bits are fixed and the lower four come from strap pins. When the address matches, the block acknowledges, pulses a conversion-start request and shifts out the conversion result as two bytes, high byte first. The least significant bit of the address byte does not select a transfer direction. When the internal reference is selected, that bit acts as a power-down request for the reference.

The block also recognises the general high-speed master code `0000_1xxx`. It answers that byte with a not-acknowledge and raises a high-speed mode flag, which the next STOP clears. The data line is open-drain, so the block only drives an output enable: when the enable is high, the pad pulls the line low.

Top module: `adc_i2c_slave`

## Requirements
- R1: A START or repeated START (SDA falling while SCL is high) restarts address reception at any point, even part-way through a byte. A STOP (SDA rising while SCL is high) returns the block to idle.
- R2: An address byte whose upper seven bits equal `{3'b011, strap_i}` is acknowledged. The block holds SDA low across the ninth SCL clock.
- R3: Any other address that is not the master code gets no acknowledge and no conversion request. SDA stays released until the next START.
- R4: Each matched address produces exactly one single-cycle pulse on `conv_start_o`.
- R5: After a match, the 16-bit `result_i` is captured at the end of the acknowledge clock. It is sent high byte first, with the most significant bit first in each byte.
- R6: A master acknowledge (SDA low) after the high byte continues with the low byte. A master not-acknowledge releases SDA, so any further clocks read as 1.
- R7: An address byte with bits [7:3] = `00001` is answered with a not-acknowledge (SDA released on the ninth clock) and sets `hs_mode_o`.
- R8: `hs_mode_o` is 0 after reset (fast/standard timing) and clears on every STOP.
- R9: On a match, `pdn_req_o` becomes `int_ref_i & ~rw`, where rw is address bit 0. With `int_ref_i` = 0 it is therefore 0. The value holds until the next matched address.
- R10: The block changes `sda_oe_o` only while SCL is low.
- R11: After reset, `sda_oe_o`, `conv_start_o`, `pdn_req_o` and `hs_mode_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls the data line low |
| strap_i | input | 4 | Static low address bits |
| int_ref_i | input | 1 | 1 selects the internal reference, enabling the power-down request |
| result_i | input | 16 | Conversion result to be returned |
| conv_start_o | output | 1 | One-cycle request to acquire and convert |
| pdn_req_o | output | 1 | Power down the reference after conversion |
| hs_mode_o | output | 1 | High-speed bus timing selected |

## Verification
The bench sweeps all 256 address byte values against one strap setting and sweeps every strap value with its matching address.

- An off-by-one address decoder would acknowledge a neighbouring address or miss its own. A loose master-code decode would also answer bytes that should be ignored.
- A read path that shifted once too often or too rarely would return a rotated result.
- A slave that ignored the master's not-acknowledge would keep pulling SDA low and block the following STOP.
- A repeated START in mid-byte that failed to clear the bit counter would misalign the next address.
- A power-down bit that was not held would change on unmatched traffic.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_TX,
      ST_TACK
   } slv_st_e;
endpackage

// File: rtl/adc_i2c_sync.sv
module adc_i2c_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[0] <= RST_VAL;
      else        q[0] <= d_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= RST_VAL;
         else        q[i] <= q[i-1];
      end
   end

   assign q_o = q[STAGES-1];
endmodule

// File: rtl/adc_i2c_cond.sv
module adc_i2c_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s_o,
   output logic sda_s_o,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   logic scl_s, sda_s, scl_q, sda_q;

   adc_i2c_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   adc_i2c_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_s_o = scl_s;
   assign sda_s_o = sda_s;
   assign start_o = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o  = scl_s & scl_q & ~sda_q & sda_s;
   assign rise_o  = scl_s & ~scl_q;
   assign fall_o  = ~scl_s & scl_q;
endmodule

// File: rtl/adc_i2c_slave.sv
module adc_i2c_slave
   import adc_i2c_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         STRAP_W     = 4,
   parameter int         RES_W       = 16,
   parameter logic [6:0] ADDR_BASE   = 7'b0110000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe_o,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               int_ref_i,
   input  logic [RES_W-1:0]   result_i,
   output logic               conv_start_o,
   output logic               pdn_req_o,
   output logic               hs_mode_o
);
   localparam int          NBYTES  = RES_W / 8;
   localparam int          BIDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam logic [BIDX_W-1:0] LAST_B = BIDX_W'(NBYTES - 1);
   localparam logic [4:0]  HS_CODE = 5'b00001;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_strap
      $error("STRAP_W must lie in 1..6");
   end
   if ((RES_W % 8) != 0 || RES_W < 8) begin : g_bad_res
      $error("RES_W must be a non-zero multiple of 8");
   end

   logic scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;

   adc_i2c_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s_o(scl_s), .sda_s_o(sda_s), .start_o(start_det),
      .stop_o(stop_det), .rise_o(scl_rise), .fall_o(scl_fall));

   logic [6:0] own_addr;
   assign own_addr = {ADDR_BASE[6:STRAP_W], strap_i};

   slv_st_e           st;
   logic [3:0]        bitcnt;
   logic [7:0]        rx_sr;
   logic [RES_W-1:0]  tx_sr;
   logic [BIDX_W-1:0] byte_idx;
   logic              matched, ack_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         bitcnt       <= '0;
         rx_sr        <= '0;
         tx_sr        <= '0;
         byte_idx     <= '0;
         matched      <= 1'b0;
         ack_ok       <= 1'b0;
         sda_oe_o     <= 1'b0;
         conv_start_o <= 1'b0;
         pdn_req_o    <= 1'b0;
         hs_mode_o    <= 1'b0;
      end else begin
         conv_start_o <= 1'b0;
         if (stop_det) begin
            st        <= ST_IDLE;
            sda_oe_o  <= 1'b0;
            hs_mode_o <= 1'b0;
         end else if (start_det) begin
            st       <= ST_ADDR;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
         end else begin
            unique case (st)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     rx_sr  <= {rx_sr[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     if (rx_sr[7:1] == own_addr) begin
                        matched      <= 1'b1;
                        sda_oe_o     <= 1'b1;
                        conv_start_o <= 1'b1;
                        pdn_req_o    <= int_ref_i & ~rx_sr[0];
                        st           <= ST_AACK;
                     end else if (rx_sr[7:3] == HS_CODE) begin
                        matched   <= 1'b0;
                        hs_mode_o <= 1'b1;
                        st        <= ST_AACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     if (matched) begin
                        tx_sr    <= result_i;
                        sda_oe_o <= ~result_i[RES_W-1];
                        bitcnt   <= '0;
                        byte_idx <= '0;
                        st       <= ST_TX;
                     end else begin
                        sda_oe_o <= 1'b0;
                        st       <= ST_IDLE;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     tx_sr <= {tx_sr[RES_W-2:0], 1'b0};
                     if (bitcnt == 4'd7) begin
                        sda_oe_o <= 1'b0;
                        bitcnt   <= '0;
                        st       <= ST_TACK;
                     end else begin
                        sda_oe_o <= ~tx_sr[RES_W-2];
                        bitcnt   <= bitcnt + 4'd1;
                     end
                  end
               end
               ST_TACK: begin
                  if (scl_rise) begin
                     ack_ok <= ~sda_s;
                  end else if (scl_fall) begin
                     if (ack_ok && byte_idx != LAST_B) begin
                        byte_idx <= byte_idx + 1'b1;
                        sda_oe_o <= ~tx_sr[RES_W-1];
                        st       <= ST_TX;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_s);                                    // R10
   AST_CONV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |=> !conv_start_o);                                // R4
   AST_HS_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !hs_mode_o);                                       // R8
   AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !stop_det) |=> (st == ST_ADDR && bitcnt == 4'd0)); // R1
   AST_PDN_EXT_REF: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start_o && !$past(int_ref_i)) |-> !pdn_req_o);            // R9
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe_o);                                 // R3
   AST_MCODE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_AACK && !matched) |-> !sda_oe_o);                     // R7
endmodule

// File: tb/adc_i2c_slave_tb.sv
module adc_i2c_slave_tb_top;
   localparam int Q = 5;
   localparam int H = 10;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1, m_sda = 1'b1;
   logic [3:0]  strap = 4'b1010;
   logic        int_ref = 1'b1;
   logic [15:0] result = 16'h0000;
   logic        sda_oe, conv_start, pdn_req, hs_mode;
   wire         sda_bus = m_sda & ~sda_oe;

   int vec = 0, errs = 0, conv_cnt = 0, r10_bad = 0;
   logic exp_pdn = 1'b0;
   logic oe_prev = 1'b0;

   adc_i2c_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .strap_i(strap), .int_ref_i(int_ref),
      .result_i(result), .conv_start_o(conv_start),
      .pdn_req_o(pdn_req), .hs_mode_o(hs_mode));

   always @(negedge clk) begin
      if (conv_start) conv_cnt++;
      if (rst_n && sda_oe != oe_prev && m_scl) r10_bad++;
      oe_prev <= sda_oe;
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired: actual hung expected done");
      finish_run();
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      vec++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
      m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
   endtask

   task automatic wbit(input logic b);
      m_sda = b; wt(Q); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(Q);
   endtask

   task automatic rbit(output logic b);
      m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(H/2); b = sda_bus;
      wt(H/2); m_scl = 1'b0; wt(Q);
   endtask

   task automatic wbyte(input logic [7:0] d);
      for (int i = 7; i >= 0; i--) wbit(d[i]);
   endtask

   task automatic rbyte(output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         logic b;
         rbit(b);
         d[i] = b;
      end
   endtask

   // Full transaction: address, then a complete two-byte read when matched.
   task automatic run_addr(input logic [7:0] a);
      logic match, mcode, ackb;
      logic [7:0] hi, lo;
      int c0;
      match = (a[7:1] == {3'b011, strap});
      mcode = (a[7:3] == 5'b00001);
      c0 = conv_cnt;
      bus_start();
      wbyte(a);
      rbit(ackb);
      if (match) chk(ackb == 1'b0, "R2 ack on match", ackb, 0);
      else       chk(ackb == 1'b1, "R3 nack on other", ackb, 1);
      if (match) begin
         rbyte(hi); wbit(1'b0); rbyte(lo); wbit(1'b1);
         chk({hi, lo} == result, "R5 result order", {hi, lo}, result);
         chk(conv_cnt == c0 + 1, "R4 one pulse", conv_cnt - c0, 1);
         exp_pdn = int_ref & ~a[0];
      end else begin
         chk(conv_cnt == c0, "R3 no conversion", conv_cnt - c0, 0);
      end
      chk(pdn_req == exp_pdn, "R9 power-down", pdn_req, exp_pdn);
      if (mcode) chk(hs_mode == 1'b1, "R7 hs flag set", hs_mode, 1);
      bus_stop();
      wt(4);
      chk(hs_mode == 1'b0, "R8 hs clear on stop", hs_mode, 0);
   endtask

   initial begin
      logic ackb;
      logic [7:0] hi, lo;
      wt(5);
      chk(sda_oe == 1'b0 && conv_start == 1'b0, "R11 reset outputs",
          {sda_oe, conv_start}, 0);
      chk(pdn_req == 1'b0, "R11 reset pdn", pdn_req, 0);
      chk(hs_mode == 1'b0, "R8 reset hs", hs_mode, 0);
      rst_n = 1'b1;
      wt(5);

      // Sweep all address bytes, internal reference, strap 1010
      for (int a = 0; a < 256; a++) begin
         result = 16'(a * 257) ^ 16'h5A3C;
         run_addr(8'(a));
      end

      // R2: every strap value with its own address
      for (int s = 0; s < 16; s++) begin
         strap  = 4'(s);
         result = 16'(s * 4099) ^ 16'hC3A5;
         run_addr({3'b011, 4'(s), 1'b1});
      end

      // R9: external reference ignores rw; held across unmatched traffic
      strap = 4'b0101;
      int_ref = 1'b1; run_addr({7'b0110101, 1'b0});
      chk(pdn_req == 1'b1, "R9 internal rw0", pdn_req, 1);
      run_addr(8'h42);
      chk(pdn_req == 1'b1, "R9 held on unmatched", pdn_req, 1);
      int_ref = 1'b0; run_addr({7'b0110101, 1'b0});
      chk(pdn_req == 1'b0, "R9 external rw0", pdn_req, 0);

      // R6: master NACK after high byte releases the line
      result = 16'h1234;
      bus_start(); wbyte({7'b0110101, 1'b1}); rbit(ackb);
      chk(ackb == 1'b0, "R6 ack", ackb, 0);
      rbyte(hi); wbit(1'b1); rbyte(lo);
      chk(hi == 8'h12, "R6 high byte", hi, 8'h12);
      chk(lo == 8'hFF, "R6 released after nack", lo, 8'hFF);
      bus_stop(); wt(4);

      // R1: repeated START in mid-byte restarts address reception
      result = 16'hBEEF;
      bus_start(); wbit(1'b1); wbit(1'b0); wbit(1'b0); wbit(1'b1);
      bus_start(); wbyte({7'b0110101, 1'b1}); rbit(ackb);
      chk(ackb == 1'b0, "R1 repeated start ack", ackb, 0);
      rbyte(hi); wbit(1'b0); rbyte(lo); wbit(1'b1);
      chk({hi, lo} == 16'hBEEF, "R1 read after restart", {hi, lo}, 16'hBEEF);
      bus_stop(); wt(4);

      chk(r10_bad == 0, "R10 sda changes with scl low", r10_bad, 0);
      finish_run();
   end
endmodule